// File: doc/BRIEF.md
# DDS Tuning Word Multiplier

This block turns an output frequency, given as an unsigned integer number of hertz, into the phase-increment word that a direct digital synthesizer needs. The frequency is multiplied by a reference constant equal to 2^32 divided by the synthesizer clock in hertz. The constant is held in fixed point, with 8 integer bits and 24 fraction bits, so the tuning word is the product shifted right by 24 and truncated.

The multiply is sequential shift-and-add. A 40-bit accumulator is cleared when a conversion starts. It then takes 32 steps, one for each constant bit, starting from the least significant bit. In each step the frequency, aligned 8 bits up, is added when the bit is set, and the accumulator then shifts right by one. The result is a 40-bit control word: the 32-bit tuning word in the low bits and a control byte on top. The control byte says whether the synthesizer's 6x reference multiplier is in use.

A host pulses `start_i` with the operands present. It waits for the one-cycle `done_o` pulse and then reads `word_o`, which stays valid until the next conversion completes.

Top module: `dds_tuneword_mult`

## Requirements
- R1: While reset is asserted and after its release, before any conversion, `done_o` is 0 and `word_o` is all zeros.
- R2: After a conversion, `word_o[31:0]` equals floor(freq × const / 2^24) mod 2^32 for the freq and const sampled with the accepted start. Each conversion begins from a cleared accumulator, so back-to-back results do not depend on each other.
- R3: A start sampled at clock edge E0 while idle produces `done_o` high during the cycle that follows edge E32, which is 32 edges later.
- R4: `word_o[39:32]` is 8'h01 if `mul6_en_i` was 1 at the accepted start, and 8'h00 otherwise.
- R5: `done_o` is high for exactly one cycle per conversion.
- R6: `word_o` changes only in the cycle in which `done_o` is high. At all other times it holds its value.
- R7: A start pulse that arrives while a conversion is running is ignored. It does not change the result or the timing, and it does not cause a second done pulse.
- R8: Changes on `freq_i`, `const_i` or `mul6_en_i` after the accepted start have no effect on that conversion's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin a conversion. Taken only when idle |
| freq_i | input | 32 | Output frequency in hertz |
| const_i | input | 32 | Reference constant, 8.24 fixed point |
| mul6_en_i | input | 1 | 1 when the 6x reference multiplier is on |
| done_o | output | 1 | One-cycle pulse when `word_o` is updated |
| word_o | output | 40 | Control byte (bits 39:32) and tuning word (bits 31:0) |

## Verification
Walking-one constants against an all-ones frequency check that every constant bit is examined and weighted correctly. Walking-one frequencies against an all-ones constant do the same for every addend bit and for the carry into the top of the accumulator. The two reference constants, used with band-edge frequencies, together with zero operands and pseudo-random pairs, check realistic products and truncation. Some conversions receive a second start and altered operands in mid-run; these separate a design that captures its operands once from one that follows its inputs.

// File: rtl/dds_tw_pkg.sv
package dds_tw_pkg;
  localparam logic [7:0] CODE_REF_DIRECT = 8'h00;
  localparam logic [7:0] CODE_REF_X6     = 8'h01;

  function automatic logic [7:0] ref_code(input logic mul6_en);
    return mul6_en ? CODE_REF_X6 : CODE_REF_DIRECT;
  endfunction
endpackage

// File: rtl/dds_tw_rst_sync.sv
module dds_tw_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/dds_tw_seq.sv
module dds_tw_seq #(
  parameter int unsigned ITER = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             accept, last;

  always_comb begin
    accept = start_i & ~busy_q;
    last   = busy_q & (cnt_q == LAST);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = last;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign load_o = accept;
  assign step_o = busy_q;
  assign fin_o  = last;
  assign done_o = done_q;

  AST_FINAL_STEP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == LAST) |=> (!busy_q && done_q)); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != LAST && start_i) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1)); // R7
endmodule

// File: rtl/dds_tw_datapath.sv
module dds_tw_datapath #(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned K_W    = 32,
  parameter int unsigned FRAC_W = 24
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic                         step_i,
  input  logic [FREQ_W-1:0]            freq_i,
  input  logic [K_W-1:0]               const_i,
  output logic [FREQ_W+K_W-FRAC_W-1:0] acc_nxt_o
);
  localparam int unsigned ACC_W = FREQ_W + K_W - FRAC_W;
  localparam int unsigned ALIGN = ACC_W - FREQ_W;

  logic [ACC_W-1:0]  acc_q, acc_d, acc_step;
  logic [K_W-1:0]    k_q, k_d;
  logic [FREQ_W-1:0] f_q, f_d;
  logic [FREQ_W:0]   sum;

  always_comb begin
    sum      = {1'b0, acc_q[ACC_W-1:ALIGN]} + (k_q[0] ? {1'b0, f_q} : '0);
    acc_step = {sum, acc_q[ALIGN-1:1]};
    acc_d    = acc_q;
    k_d      = k_q;
    f_d      = f_q;
    if (load_i) begin
      acc_d = '0;
      k_d   = const_i;
      f_d   = freq_i;
    end else if (step_i) begin
      acc_d = acc_step;
      k_d   = k_q >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      k_q   <= '0;
      f_q   <= '0;
    end else begin
      acc_q <= acc_d;
      k_q   <= k_d;
      f_q   <= f_d;
    end
  end

  assign acc_nxt_o = acc_step;

  AST_OPERAND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i) |=> $stable(f_q)); // R8
endmodule

// File: rtl/dds_tuneword_mult.sv
module dds_tuneword_mult #(
  parameter int unsigned FREQ_W = 32,
  parameter int unsigned K_W    = 32,
  parameter int unsigned FRAC_W = 24,
  parameter int unsigned CODE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [FREQ_W-1:0]        freq_i,
  input  logic [K_W-1:0]           const_i,
  input  logic                     mul6_en_i,
  output logic                     done_o,
  output logic [FREQ_W+CODE_W-1:0] word_o
);
  import dds_tw_pkg::*;

  localparam int unsigned ACC_W = FREQ_W + K_W - FRAC_W;
  localparam int unsigned OUT_W = FREQ_W + CODE_W;

  logic             rst_n;
  logic             load, step, fin;
  logic [ACC_W-1:0] acc_nxt;
  logic [CODE_W-1:0] code_q, code_d;
  logic [OUT_W-1:0] word_q, word_d;

  dds_tw_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  dds_tw_seq #(.ITER(K_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .fin_o   (fin),
    .done_o  (done_o)
  );

  dds_tw_datapath #(.FREQ_W(FREQ_W), .K_W(K_W), .FRAC_W(FRAC_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .load_i    (load),
    .step_i    (step),
    .freq_i    (freq_i),
    .const_i   (const_i),
    .acc_nxt_o (acc_nxt)
  );

  always_comb begin
    code_d = load ? CODE_W'(ref_code(mul6_en_i)) : code_q;
    word_d = fin  ? {code_q, acc_nxt[FREQ_W-1:0]} : word_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      word_q <= '0;
    end else begin
      code_q <= code_d;
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_WORD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
    !done_o |-> $stable(word_o)); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> (word_o[OUT_W-1:FREQ_W+1] == '0)); // R4
endmodule

// File: tb/dds_tuneword_mult_bench.sv
module dds_tuneword_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] freq = '0;
  logic [31:0] kval = '0;
  logic        m6 = 1'b0;
  logic        done;
  logic [39:0] word;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dds_tuneword_mult u_dds_tuneword_mult (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_i(freq),
    .const_i(kval), .mul6_en_i(m6), .done_o(done), .word_o(word)
  );

  function automatic logic [31:0] exp_tw(input logic [31:0] f, input logic [31:0] k);
    logic [63:0] p;
    p = {32'b0, f} * {32'b0, k};
    return p[55:24];
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // disturb: second start and changed operands mid-run (R7, R8)
  task automatic convert(input logic [31:0] f, input logic [31:0] k, input logic m, input bit disturb);
    int first_done = 0;
    int n_done = 0;
    logic [39:0] exp_w;
    logic [39:0] w_at_done = '0;
    exp_w = {7'b0, m, exp_tw(f, k)};
    @(negedge clk);
    freq = f; kval = k; m6 = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 40; c++) begin
      if (disturb && c == 5) begin
        freq = ~f; kval = k ^ 32'h5A5A_0F0F; m6 = ~m; start = 1'b1;
      end
      if (disturb && c == 6) start = 1'b0;
      @(negedge clk);
      if (done) begin
        n_done++;
        if (first_done == 0) begin first_done = c; w_at_done = word; end
      end
    end
    chk(disturb ? "R3/R7 latency" : "R3 latency", 40'(first_done), 40'd32);
    chk(disturb ? "R5/R7 pulses" : "R5 pulses", 40'(n_done), 40'd1);
    chk(disturb ? "R2/R8 tuning word" : "R2 tuning word", {8'b0, w_at_done[31:0]}, {8'b0, exp_w[31:0]});
    chk(disturb ? "R4/R8 control byte" : "R4 control byte", {32'b0, w_at_done[39:32]}, {32'b0, exp_w[39:32]});
    chk("R6 word held", word, exp_w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [31:0] lk;
    repeat (3) @(negedge clk);
    chk("R1 reset done", {39'b0, done}, 40'd0);
    chk("R1 reset word", word, 40'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle done", {39'b0, done}, 40'd0);
    chk("R1 idle word", word, 40'd0);

    convert(32'd7_030_000, 32'h225C17D0, 1'b0, 1'b0);
    convert(32'd7_000_000, 32'h225C17D0, 1'b0, 1'b0);
    convert(32'd7_200_000, 32'h17DC65DE, 1'b1, 1'b0);
    convert(32'd0, 32'h17DC65DE, 1'b1, 1'b0);
    convert(32'hFFFF_FFFF, 32'd0, 1'b0, 1'b0);
    convert(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    convert(32'd1, 32'h0100_0000, 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) convert(32'hFFFF_FFFF, 32'd1 << i, i[0], 1'b0);
    for (int i = 0; i < 32; i++) convert(32'd1 << i, 32'hFFFF_FFFF, i[1], 1'b0);
    lf = 32'h1234_5678; lk = 32'h8765_4321;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lk = {lk[30:0], lk[31] ^ lk[21] ^ lk[1] ^ lk[0]};
      convert(lf, lk, lf[3], 1'b0);
    end
    convert(32'd7_030_000, 32'h225C17D0, 1'b0, 1'b1);
    convert(32'd14_250_000, 32'h17DC65DE, 1'b1, 1'b1);
    convert(32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule